// File: doc/BRIEF.md
# Translation Mode and Privileged Jump Controller

This block holds the address-translation mode of a processor: whether translation is on, which of two maps (system or user) is active, and a fence value. It carries out the jumps that change that mode in one step. Each such jump can set the mode, save a return link, redirect the program counter and drop the interrupt-enable flag. It also loads the fence. The mode is always visible as one packed status word.

A command is presented for one cycle with `cmd_valid` high. All results appear on registered outputs one clock later. Results are either a program-counter load, an optional memory write of the return link, an interrupt-enable clear pulse, or a violation pulse. The privilege test and the low-target test are made against the mode held before the command. A command that is refused leaves every piece of state untouched.

Top module: `xlat_ctl`

## Requirements
- R1: After synchronous reset the status word is 0 (translation off, system map, fence 0), and `p_load`, `mem_we`, `ie_clear` and `viol` are low.
- R2: Op 1 (restore jump) sets the translation-enable bit from `cmd_word[15]` and the user-map bit from `cmd_word[14]`, and loads `p_next` with `cmd_target`.
- R3: The fixed-mode jumps set the mode as follows. Ops 2/3 turn translation off with the system map. Ops 4/5 turn it on with the system map. Ops 6/7 turn it on with the user map.
- R4: The link forms (ops 3, 5, 7) write `{1'b0, cur_p}` to address `cmd_target` and load `p_next` with `cmd_target + 1` modulo 2^15. The other jumps (ops 1, 2, 4, 6) do not write memory.
- R5: Every accepted jump (ops 1 to 7) raises `ie_clear` for one cycle, together with `p_load`.
- R6: With `prot_on` high, a non-link jump (ops 1, 2, 4, 6) whose target is below 2 is refused. With `prot_on` low the same jump is accepted.
- R7: A jump or a fence load (op 8) is a privilege violation only when the user map is active and `prot_on` is high. With the system map active, or with protection off, it is accepted.
- R8: A refused command raises `viol` for one cycle. It changes neither the status word nor P, writes no memory and raises no `ie_clear`.
- R9: Op 8 copies the low 10 bits of `reg_val` into the fence. It loads no P and raises no `ie_clear`.
- R10: `status` packs translation-enable in bit 15, user map in bit 14, zeros in bits 13:10 and the fence in bits 9:0. It shows the mode after each command in the cycle after that command.
- R11: Op 0 and ops 9 to 15, and any cycle with `cmd_valid` low, change nothing and raise no output pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (0 idle, 1 restore jump, 2-7 fixed-mode jumps, 8 fence load) |
| cmd_word | input | 16 | Mode word for the restore jump |
| cmd_target | input | 15 | Jump target address |
| cur_p | input | 15 | Current program counter, saved by link forms |
| prot_on | input | 1 | Protected mode active |
| reg_val | input | 16 | Selected accumulator value for fence load |
| p_load | output | 1 | One-cycle pulse: load `p_next` into P |
| p_next | output | 15 | New program counter |
| mem_we | output | 1 | One-cycle return-link write strobe |
| mem_addr | output | 15 | Return-link write address |
| mem_data | output | 16 | Return-link write data |
| ie_clear | output | 1 | One-cycle interrupt-enable clear pulse |
| viol | output | 1 | One-cycle refusal pulse |
| status | output | 16 | Packed mode and fence |

## Verification
The bench walks all sixteen command codes. It starts each command from every one of the four enable/map starting modes, with protection both off and on. Targets are 0, 1, 2, a mid value and the top address. Targets 0 and 1 against 2 separate the low-bound refusal from acceptance, and only for plain jumps. The top address shows the link form's wrap to zero. Starting from the user map against the system map, with and without protection, separates a privilege refusal from an accepted jump or fence load. The unused codes and idle cycles show that nothing moves without an accepted command.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [3:0] {
        XOP_IDLE    = 4'd0,
        XOP_RESTORE = 4'd1,
        XOP_OFF_JMP = 4'd2,
        XOP_OFF_LNK = 4'd3,
        XOP_SYS_JMP = 4'd4,
        XOP_SYS_LNK = 4'd5,
        XOP_USR_JMP = 4'd6,
        XOP_USR_LNK = 4'd7,
        XOP_FENCE   = 4'd8
    } xop_e;

    // decoded command
    typedef struct packed {
        logic jump;     // mode-changing jump
        logic link;     // saves return link, continues at target+1
        logic fence;    // fence load
        logic chk_low;  // subject to the low-target test
        logic en;       // translation enable after jump
        logic usr;      // user map after jump
    } xcmd_t;

    typedef struct packed {
        logic en;
        logic usr;
    } xmode_t;

    function automatic xcmd_t xlat_decode(input logic [3:0] op,
                                          input logic       word_en,
                                          input logic       word_usr);
        xcmd_t c;
        c = '0;
        case (op)
            XOP_RESTORE: begin c.jump = 1'b1; c.chk_low = 1'b1;
                               c.en = word_en; c.usr = word_usr; end
            XOP_OFF_JMP: begin c.jump = 1'b1; c.chk_low = 1'b1; end
            XOP_OFF_LNK: begin c.jump = 1'b1; c.link = 1'b1; end
            XOP_SYS_JMP: begin c.jump = 1'b1; c.chk_low = 1'b1; c.en = 1'b1; end
            XOP_SYS_LNK: begin c.jump = 1'b1; c.link = 1'b1; c.en = 1'b1; end
            XOP_USR_JMP: begin c.jump = 1'b1; c.chk_low = 1'b1;
                               c.en = 1'b1; c.usr = 1'b1; end
            XOP_USR_LNK: begin c.jump = 1'b1; c.link = 1'b1;
                               c.en = 1'b1; c.usr = 1'b1; end
            XOP_FENCE:   c.fence = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xlat_guard.sv
module xlat_guard
    import xlat_pkg::*;
#(
    parameter int P_W       = 15,
    parameter int LOW_LIMIT = 2
) (
    input  logic           cmd_valid,
    input  xcmd_t          cmd,
    input  logic [P_W-1:0] target,
    input  logic           prot_on,
    input  logic           usr_sel,
    output logic           accept,
    output logic           fault
);
    localparam logic [P_W-1:0] LOW_T = P_W'(LOW_LIMIT);

    logic acts;
    logic priv_bad;
    logic low_bad;

    always_comb begin
        acts     = cmd_valid && (cmd.jump || cmd.fence);
        priv_bad = prot_on && usr_sel;
        low_bad  = prot_on && cmd.chk_low && (target < LOW_T);
        fault    = acts && (priv_bad || low_bad);
        accept   = acts && !fault;
    end

endmodule

// File: rtl/xlat_state.sv
module xlat_state
    import xlat_pkg::*;
#(
    parameter int DW      = 16,
    parameter int FENCE_W = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          fault,
    input  xcmd_t         cmd,
    input  logic [DW-1:0] fence_in,
    output xmode_t        mode,
    output logic [DW-1:0] status
);
    localparam int EN_BIT  = DW - 1;
    localparam int USR_BIT = DW - 2;

    logic [FENCE_W-1:0] fence_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            fence_q <= '0;
        end else if (accept) begin
            if (cmd.jump) begin
                mode.en  <= cmd.en;
                mode.usr <= cmd.usr;
            end
            if (cmd.fence)
                fence_q <= fence_in[FENCE_W-1:0];
        end
    end

    always_comb begin
        status                = '0;
        status[EN_BIT]        = mode.en;
        status[USR_BIT]       = mode.usr;
        status[FENCE_W-1:0]   = fence_q;
    end

    AST_HOLD_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        fault |=> $stable(status)); // R8

    AST_FENCE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd.fence) |=> (status[FENCE_W-1:0] == $past(fence_in[FENCE_W-1:0]))); // R9

    AST_FENCE_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd.fence) |=> $stable(status[DW-1:DW-2])); // R9

endmodule

// File: rtl/xlat_flow.sv
module xlat_flow
    import xlat_pkg::*;
#(
    parameter int P_W = 15,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           fault,
    input  xcmd_t          cmd,
    input  logic [P_W-1:0] target,
    input  logic [P_W-1:0] cur_p,
    output logic           p_load,
    output logic [P_W-1:0] p_next,
    output logic           mem_we,
    output logic [P_W-1:0] mem_addr,
    output logic [DW-1:0]  mem_data,
    output logic           ie_clear,
    output logic           viol
);
    logic           do_jump;
    logic [P_W-1:0] dest;

    always_comb begin
        do_jump = accept && cmd.jump;
        dest    = cmd.link ? P_W'(target + 1'b1) : target;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_load   <= 1'b0;
            p_next   <= '0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            ie_clear <= 1'b0;
            viol     <= 1'b0;
        end else begin
            p_load   <= do_jump;
            ie_clear <= do_jump;
            mem_we   <= do_jump && cmd.link;
            viol     <= fault;
            if (do_jump)
                p_next <= dest;
            if (do_jump && cmd.link) begin
                mem_addr <= target;
                mem_data <= DW'(cur_p);
            end
        end
    end

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        viol |-> (!p_load && !mem_we && !ie_clear)); // R8

    AST_IE_WITH_JUMP: assert property (@(posedge clk) disable iff (rst)
        ie_clear |-> p_load); // R5

    AST_LINK_NEXT: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (p_next == P_W'(mem_addr + 1'b1))); // R4

    AST_LINK_DATA_TOP: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_data[DW-1] == 1'b0)); // R4

endmodule

// File: rtl/xlat_ctl.sv
module xlat_ctl
    import xlat_pkg::*;
#(
    parameter int P_W       = 15,
    parameter int DW        = 16,
    parameter int FENCE_W   = 10,
    parameter int LOW_LIMIT = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_op,
    input  logic [DW-1:0]  cmd_word,
    input  logic [P_W-1:0] cmd_target,
    input  logic [P_W-1:0] cur_p,
    input  logic           prot_on,
    input  logic [DW-1:0]  reg_val,
    output logic           p_load,
    output logic [P_W-1:0] p_next,
    output logic           mem_we,
    output logic [P_W-1:0] mem_addr,
    output logic [DW-1:0]  mem_data,
    output logic           ie_clear,
    output logic           viol,
    output logic [DW-1:0]  status
);
    xcmd_t  cmd;
    xmode_t mode;
    logic   accept;
    logic   fault;

    always_comb cmd = xlat_decode(cmd_op, cmd_word[DW-1], cmd_word[DW-2]);

    xlat_guard #(.P_W(P_W), .LOW_LIMIT(LOW_LIMIT)) i_guard (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .target    (cmd_target),
        .prot_on   (prot_on),
        .usr_sel   (mode.usr),
        .accept    (accept),
        .fault     (fault)
    );

    xlat_state #(.DW(DW), .FENCE_W(FENCE_W)) i_state (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .fault    (fault),
        .cmd      (cmd),
        .fence_in (reg_val),
        .mode     (mode),
        .status   (status)
    );

    xlat_flow #(.P_W(P_W), .DW(DW)) i_flow (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .fault    (fault),
        .cmd      (cmd),
        .target   (cmd_target),
        .cur_p    (cur_p),
        .p_load   (p_load),
        .p_next   (p_next),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .ie_clear (ie_clear),
        .viol     (viol)
    );

    AST_FAULT_NEEDS_PROT: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(prot_on)); // R7

    AST_LOW_TARGET: assert property (@(posedge clk) disable iff (rst)
        (p_load && !mem_we && $past(prot_on)) |-> (p_next >= P_W'(LOW_LIMIT))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(cmd_valid) |-> (!p_load && !viol && !mem_we)); // R11

    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(status)); // R11

endmodule

// File: tb/test_xlat_ctl.sv
module test_xlat_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [15:0] cmd_word = '0;
    logic [14:0] cmd_target = '0;
    logic [14:0] cur_p = '0;
    logic        prot_on = 1'b0;
    logic [15:0] reg_val = '0;
    logic        p_load, mem_we, ie_clear, viol;
    logic [14:0] p_next, mem_addr;
    logic [15:0] mem_data, status;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference model state
    logic          m_en = 1'b0;
    logic          m_usr = 1'b0;
    logic [FW-1:0] m_fence = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_ctl #(.P_W(15), .DW(16), .FENCE_W(FW), .LOW_LIMIT(2)) i_xlat_ctl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_target(cmd_target), .cur_p(cur_p),
        .prot_on(prot_on), .reg_val(reg_val), .p_load(p_load), .p_next(p_next),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .ie_clear(ie_clear), .viol(viol), .status(status)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        return {m_en, m_usr, {(14-FW){1'b0}}, m_fence};
    endfunction

    // called at a falling edge; returns at a falling edge
    task automatic run_cmd(input logic [3:0] op, input logic [15:0] wd,
                           input logic [14:0] tgt, input logic [14:0] cp,
                           input logic pr, input logic [15:0] rv);
        logic is_jump, is_link, is_fence, chk_low, pv, lo, bad, ok;
        logic n_en, n_usr;
        string tag;
        is_jump  = (op >= 4'd1) && (op <= 4'd7);
        is_link  = (op == 4'd3) || (op == 4'd5) || (op == 4'd7);
        is_fence = (op == 4'd8);
        chk_low  = is_jump && !is_link;
        pv  = pr && m_usr && (is_jump || is_fence);
        lo  = pr && chk_low && (tgt < 15'd2);
        bad = pv || lo;
        ok  = (is_jump || is_fence) && !bad;
        case (op)
            4'd1:        begin n_en = wd[15]; n_usr = wd[14]; end
            4'd2, 4'd3:  begin n_en = 1'b0;   n_usr = 1'b0;   end
            4'd4, 4'd5:  begin n_en = 1'b1;   n_usr = 1'b0;   end
            default:     begin n_en = 1'b1;   n_usr = 1'b1;   end
        endcase
        if (bad)           tag = lo ? "R6" : "R7";
        else if (is_fence) tag = "R9";
        else if (is_link)  tag = "R4";
        else if (op == 4'd1) tag = "R2";
        else if (is_jump)  tag = "R3";
        else               tag = "R11";

        cmd_valid = 1'b1; cmd_op = op; cmd_word = wd; cmd_target = tgt;
        cur_p = cp; prot_on = pr; reg_val = rv;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;

        if (ok && is_jump) begin m_en = n_en; m_usr = n_usr; end
        if (ok && is_fence) m_fence = rv[FW-1:0];

        chk(tag, "p_load", p_load, ok && is_jump);
        if (ok && is_jump)
            chk(tag, "p_next", p_next, is_link ? 15'(tgt + 15'd1) : tgt);
        chk(tag, "mem_we", mem_we, ok && is_link);
        if (ok && is_link) begin
            chk("R4", "mem_addr", mem_addr, tgt);
            chk("R4", "mem_data", mem_data, {1'b0, cp});
        end
        chk("R5", "ie_clear", ie_clear, ok && is_jump);
        chk(bad ? tag : "R8", "viol", viol, bad);
        chk(bad ? "R8" : "R10", "status", status, exp_status());
    endtask

    task automatic set_mode(input logic en, input logic usr);
        run_cmd(4'd1, {en, usr, 14'h0}, 15'h0100, 15'h0, 1'b0, 16'h0);
    endtask

    initial begin
        logic [14:0] tg [5];
        tg[0] = 15'h0000; tg[1] = 15'h0001; tg[2] = 15'h0002;
        tg[3] = 15'h1234; tg[4] = 15'h7FFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "status", status, 16'h0);
        chk("R1", "pulses", {p_load, mem_we, ie_clear, viol}, 4'b0);

        for (int op = 0; op < 16; op++)
            for (int m = 0; m < 4; m++)
                for (int pr = 0; pr < 2; pr++)
                    for (int t = 0; t < 5; t++) begin
                        set_mode(m[1], m[0]);
                        run_cmd(4'(op), {t[1], t[0], 14'h2A5},
                                tg[t], 15'h2AAA ^ tg[t], pr[0],
                                16'hA5C3 ^ 16'(t * 16'h0111));
                    end

        // R11: idle cycle with a jump code present but no valid
        set_mode(1'b1, 1'b1);
        cmd_valid = 1'b0; cmd_op = 4'd2; cmd_target = 15'h0040; prot_on = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "idle pulses", {p_load, mem_we, ie_clear, viol}, 4'b0);
        chk("R11", "idle status", status, exp_status());

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule